// File: doc/BRIEF.md
# Single-Error-Correcting 11-Bit Packet Codec

This block protects a 7-bit data word with 4 parity bits, so that any one bit flip anywhere in the resulting 11-bit packet can be repaired. The encoder side takes a data word and emits the packet. The decoder side takes a received packet, works out a 4-bit syndrome, flips the bit that the syndrome names, and returns the repaired data word. It also reports whether a repair was made or whether the syndrome pointed at no packet position at all.

The two sides are independent pipelines that share only the clock and reset. Each has a valid-in strobe and a valid-out strobe with exactly one clock of latency and no back-pressure. Data bits are named A (most significant) to G. Parity bits are named W to Z. Every parity bit is the even parity (XOR) of a fixed subset of the data bits. Data bits A and B fall in the same three of those subsets, and only parity Z tells them apart.

Top module: `sec_codec`

## Requirements
- R1: The encoder packet is {A,B,C,D,E,F,G,W,X,Y,Z} from bit 10 down to bit 0, with the data word (A at its bit 6) in bits 10:4. The parity bits are W=A^B^C^D^E, X=A^B^F, Y=A^B^C^D^G and Z=A^C^E^F^G.
- R2: `enc_valid_o` is high in exactly the cycle after a cycle with `enc_valid_i` high, and `enc_packet_o` in that cycle is the encoding of the word that was presented.
- R3: A received packet whose parity agrees with its data gives syndrome 0, the data bits unchanged, and both flags low.
- R4: A packet with exactly one data bit flipped gives the original data word with `dec_corrected_o` high and `dec_uncorrectable_o` low.
- R5: A packet with exactly one parity bit flipped gives the original data word with `dec_corrected_o` high.
- R6: `dec_syndrome_o` is {W,X,Y,Z} (W in bit 3), each bit being the received parity bit XOR the parity recomputed from the received data bits.
- R7: A nonzero syndrome that names no position (0110, 0111, 1100 or 1101) sets `dec_uncorrectable_o`, clears `dec_corrected_o`, and passes the received data bits through unchanged.
- R8: `dec_valid_o` is high in exactly the cycle after a cycle with `dec_valid_i` high.
- R9: A synchronous active-low reset clears both valid outputs, the packet, the data, the syndrome and both flags to zero, even if a valid input is present in the same cycle.
- R10: When a side's valid input is low, that side's data outputs and flags keep their previous values.
- R11: The encoder and the decoder accept items in the same cycle without affecting each other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| enc_valid_i | input | 1 | Encoder input strobe |
| enc_data_i | input | 7 | Data word to encode, A in bit 6 |
| enc_valid_o | output | 1 | Encoder output strobe |
| enc_packet_o | output | 11 | Encoded packet |
| dec_valid_i | input | 1 | Decoder input strobe |
| dec_packet_i | input | 11 | Received packet |
| dec_valid_o | output | 1 | Decoder output strobe |
| dec_data_o | output | 7 | Repaired data word |
| dec_syndrome_o | output | 4 | Syndrome, W in bit 3 |
| dec_corrected_o | output | 1 | A single bit was repaired |
| dec_uncorrectable_o | output | 1 | The syndrome named no position |

## Verification
Encoding and decoding can occur in the same clock. The bench keeps both strobes high on nearly every cycle: the encoder walks through a shifted sequence of words while the decoder takes all 128 words, clean and with each of the 11 single flips, then the unmatched double flips. Each side's results are popped from a separate scoreboard queue and checked on their due cycle. An idle cycle after each word lets the bench confirm that both sides hold their outputs while the other side's traffic resumes.

// File: rtl/sec_pkg.sv
// Shared constants and code tables for the 11-bit single-error-correcting codec.
// Assumes the parity subsets below are fixed; signatures are derived from them.
package sec_pkg;
    localparam int DATA_W = 7;
    localparam int PAR_W  = 4;
    localparam int PKT_W  = DATA_W + PAR_W;

    // Data-bit subset feeding parity p (p=0 is W ... p=3 is Z); bit 6 of the mask is A.
    function automatic logic [DATA_W-1:0] parity_mask(input int p);
        case (p)
            0:       return 7'b1111100;  // A B C D E
            1:       return 7'b1100010;  // A B F
            2:       return 7'b1111001;  // A B C D G
            default: return 7'b1010111;  // A C E F G
        endcase
    endfunction

    // Syndrome produced by a flip at packet position pos (bit 3 of the result is W).
    function automatic logic [PAR_W-1:0] position_signature(input int pos);
        logic [PAR_W-1:0] sig;
        logic [DATA_W-1:0] m;
        sig = '0;
        if (pos < PAR_W) begin
            sig[pos] = 1'b1;
        end else begin
            for (int p = 0; p < PAR_W; p++) begin
                m = parity_mask(p);
                sig[PAR_W-1-p] = m[pos-PAR_W];
            end
        end
        return sig;
    endfunction
endpackage

// File: rtl/sec_parity_gen.sv
// Combinational parity generator: one even-parity bit per subset of the data word.
// Assumes the subsets come from sec_pkg::parity_mask; output bit 3 is W.
module sec_parity_gen
    import sec_pkg::*;
(
    input  logic [DATA_W-1:0] data_i,
    output logic [PAR_W-1:0]  parity_o
);
    for (genvar p = 0; p < PAR_W; p++) begin : g_par
        localparam logic [DATA_W-1:0] MASK = parity_mask(p);
        // Reduce the masked data word to one parity bit.
        assign parity_o[PAR_W-1-p] = ^(data_i & MASK);
    end
endmodule

// File: rtl/sec_syndrome_locator.sv
// Maps a syndrome to a one-hot flip mask over the packet positions.
// Assumes every position signature is distinct and nonzero; an all-zero mask means no match.
module sec_syndrome_locator
    import sec_pkg::*;
(
    input  logic [PAR_W-1:0] syndrome_i,
    output logic [PKT_W-1:0] flip_o,
    output logic             match_o
);
    for (genvar i = 0; i < PKT_W; i++) begin : g_pos
        localparam logic [PAR_W-1:0] SIG = position_signature(i);
        // Flag the position whose signature equals the syndrome.
        assign flip_o[i] = (syndrome_i == SIG);
    end

    // Any hit means the syndrome names a real position.
    assign match_o = |flip_o;
endmodule

// File: rtl/sec_encoder.sv
// Registered encoder: appends four parity bits to the data word, one clock of latency.
// Assumes the caller treats packet_o as meaningful only while valid_o is high.
module sec_encoder
    import sec_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              valid_i,
    input  logic [DATA_W-1:0] data_i,
    output logic              valid_o,
    output logic [PKT_W-1:0]  packet_o
);
    logic [PAR_W-1:0] par;

    sec_parity_gen u_gen (
        .data_i  (data_i),
        .parity_o(par)
    );

    // Capture the packet on a valid input; hold it otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_o  <= 1'b0;
            packet_o <= '0;
        end else begin
            valid_o <= valid_i;
            if (valid_i) begin
                packet_o <= {data_i, par};
            end
        end
    end
endmodule

// File: rtl/sec_decoder.sv
// Registered decoder: recomputes parity, forms the syndrome, repairs a single flip.
// Assumes at most one flip for a correct repair; unmatched syndromes pass data through.
module sec_decoder
    import sec_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              valid_i,
    input  logic [PKT_W-1:0]  packet_i,
    output logic              valid_o,
    output logic [DATA_W-1:0] data_o,
    output logic [PAR_W-1:0]  syndrome_o,
    output logic              corrected_o,
    output logic              uncorrectable_o
);
    logic [PAR_W-1:0] recalc;
    logic [PAR_W-1:0] syndrome;
    logic [PKT_W-1:0] flip;
    logic             match;
    logic [PKT_W-1:0] repaired;

    sec_parity_gen u_gen (
        .data_i  (packet_i[PKT_W-1:PAR_W]),
        .parity_o(recalc)
    );

    // Compare the received parity bits with the recomputed ones.
    assign syndrome = recalc ^ packet_i[PAR_W-1:0];

    sec_syndrome_locator u_loc (
        .syndrome_i(syndrome),
        .flip_o    (flip),
        .match_o   (match)
    );

    // Invert the single bit the locator names (no change when nothing matches).
    assign repaired = packet_i ^ flip;

    // Register the repaired word and the status on a valid input.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_o         <= 1'b0;
            data_o          <= '0;
            syndrome_o      <= '0;
            corrected_o     <= 1'b0;
            uncorrectable_o <= 1'b0;
        end else begin
            valid_o <= valid_i;
            if (valid_i) begin
                data_o          <= repaired[PKT_W-1:PAR_W];
                syndrome_o      <= syndrome;
                corrected_o     <= match;
                uncorrectable_o <= (syndrome != '0) && !match;
            end
        end
    end
endmodule

// File: rtl/sec_codec.sv
// Top level: independent encoder and decoder pipelines sharing clock and reset.
// Assumes no back-pressure; each side produces one result per accepted input.
module sec_codec
    import sec_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enc_valid_i,
    input  logic [DATA_W-1:0] enc_data_i,
    output logic              enc_valid_o,
    output logic [PKT_W-1:0]  enc_packet_o,
    input  logic              dec_valid_i,
    input  logic [PKT_W-1:0]  dec_packet_i,
    output logic              dec_valid_o,
    output logic [DATA_W-1:0] dec_data_o,
    output logic [PAR_W-1:0]  dec_syndrome_o,
    output logic              dec_corrected_o,
    output logic              dec_uncorrectable_o
);
    sec_encoder u_enc (
        .clk     (clk),
        .rst_n   (rst_n),
        .valid_i (enc_valid_i),
        .data_i  (enc_data_i),
        .valid_o (enc_valid_o),
        .packet_o(enc_packet_o)
    );

    sec_decoder u_dec (
        .clk            (clk),
        .rst_n          (rst_n),
        .valid_i        (dec_valid_i),
        .packet_i       (dec_packet_i),
        .valid_o        (dec_valid_o),
        .data_o         (dec_data_o),
        .syndrome_o     (dec_syndrome_o),
        .corrected_o    (dec_corrected_o),
        .uncorrectable_o(dec_uncorrectable_o)
    );
endmodule

// File: rtl/sec_codec_chk.sv
// Checker for sec_codec: handshake timing, flag consistency and output hold.
// Assumes it is bound to every sec_codec instance.
module sec_codec_chk
    import sec_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              enc_valid_i,
    input logic              enc_valid_o,
    input logic [PKT_W-1:0]  enc_packet_o,
    input logic              dec_valid_i,
    input logic              dec_valid_o,
    input logic [DATA_W-1:0] dec_data_o,
    input logic [PAR_W-1:0]  dec_syndrome_o,
    input logic              dec_corrected_o,
    input logic              dec_uncorrectable_o
);
    assert_enc_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
        enc_valid_i |=> enc_valid_o);
    assert_enc_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !enc_valid_i |=> !enc_valid_o);
    assert_dec_latency_R8: assert property (@(posedge clk) disable iff (!rst_n)
        dec_valid_i |=> dec_valid_o);
    assert_dec_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !dec_valid_i |=> !dec_valid_o);
    assert_enc_parity_x_R1: assert property (@(posedge clk) disable iff (!rst_n)
        enc_valid_o |-> (enc_packet_o[2] == (enc_packet_o[10] ^ enc_packet_o[9] ^ enc_packet_o[5])));
    assert_flags_exclusive_R7: assert property (@(posedge clk) disable iff (!rst_n)
        dec_valid_o |-> !(dec_corrected_o && dec_uncorrectable_o));
    assert_clean_no_flags_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid_o && dec_syndrome_o == '0) |-> (!dec_corrected_o && !dec_uncorrectable_o));
    assert_dec_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !dec_valid_i |=> ($stable(dec_data_o) && $stable(dec_syndrome_o) && $stable(dec_corrected_o)));
    assert_enc_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !enc_valid_i |=> $stable(enc_packet_o));
endmodule

bind sec_codec sec_codec_chk chk_i (
    .clk                (clk),
    .rst_n              (rst_n),
    .enc_valid_i        (enc_valid_i),
    .enc_valid_o        (enc_valid_o),
    .enc_packet_o       (enc_packet_o),
    .dec_valid_i        (dec_valid_i),
    .dec_valid_o        (dec_valid_o),
    .dec_data_o         (dec_data_o),
    .dec_syndrome_o     (dec_syndrome_o),
    .dec_corrected_o    (dec_corrected_o),
    .dec_uncorrectable_o(dec_uncorrectable_o)
);

// File: tb/sec_codec_tb_top.sv
// Scoreboard bench: the driver queues expected results, the monitor pops and compares.
module sec_codec_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enc_valid_i = 1'b0;
    logic [6:0]  enc_data_i = '0;
    logic        enc_valid_o;
    logic [10:0] enc_packet_o;
    logic        dec_valid_i = 1'b0;
    logic [10:0] dec_packet_i = '0;
    logic        dec_valid_o;
    logic [6:0]  dec_data_o;
    logic [3:0]  dec_syndrome_o;
    logic        dec_corrected_o;
    logic        dec_uncorrectable_o;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit finished = 0;
    logic rst_at_edge = 1'b0;

    typedef struct {
        logic [10:0] pkt;
        int          due;
    } enc_item_t;

    typedef struct {
        logic [6:0] data;
        logic [3:0] syn;
        logic       corr;
        logic       unc;
        int         due;
        string      req;
    } dec_item_t;

    enc_item_t enc_q[$];
    dec_item_t dec_q[$];

    sec_codec dut_i (
        .clk                (clk),
        .rst_n              (rst_n),
        .enc_valid_i        (enc_valid_i),
        .enc_data_i         (enc_data_i),
        .enc_valid_o        (enc_valid_o),
        .enc_packet_o       (enc_packet_o),
        .dec_valid_i        (dec_valid_i),
        .dec_packet_i       (dec_packet_i),
        .dec_valid_o        (dec_valid_o),
        .dec_data_o         (dec_data_o),
        .dec_syndrome_o     (dec_syndrome_o),
        .dec_corrected_o    (dec_corrected_o),
        .dec_uncorrectable_o(dec_uncorrectable_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Cycle count and reset as seen at each rising edge.
    always @(posedge clk) begin
        cyc <= cyc + 1;
        rst_at_edge <= rst_n;
    end

    // Reference parity {W,X,Y,Z} written from the letter equations.
    function automatic logic [3:0] ref_par(input logic [6:0] d);
        logic a, b, c, e, f, g, dd;
        a = d[6]; b = d[5]; c = d[4]; dd = d[3]; e = d[2]; f = d[1]; g = d[0];
        return {a ^ b ^ c ^ dd ^ e, a ^ b ^ f, a ^ b ^ c ^ dd ^ g, a ^ c ^ e ^ f ^ g};
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    // Drive one cycle on both sides and queue what each side should produce.
    task automatic step(input bit ev, input logic [6:0] ed, input bit dv,
                        input logic [10:0] dp, input logic [6:0] exp_data,
                        input bit exp_corr, input bit exp_unc, input string req);
        enc_item_t ei;
        dec_item_t di;
        @(negedge clk);
        enc_valid_i  = ev;
        enc_data_i   = ed;
        dec_valid_i  = dv;
        dec_packet_i = dp;
        if (ev) begin
            ei.pkt = {ed, ref_par(ed)};
            ei.due = cyc + 1;
            enc_q.push_back(ei);
        end
        if (dv) begin
            di.data = exp_data;
            di.syn  = ref_par(dp[10:4]) ^ dp[3:0];
            di.corr = exp_corr;
            di.unc  = exp_unc;
            di.due  = cyc + 1;
            di.req  = req;
            dec_q.push_back(di);
        end
    endtask

    // Monitor: compare each result with the front of its queue; check hold while idle.
    logic [10:0] last_pkt = '0;
    logic [6:0]  last_data = '0;
    logic [3:0]  last_syn = '0;
    logic        last_corr = 1'b0;
    always @(negedge clk) begin
        if (rst_at_edge) begin
            if (enc_valid_o) begin
                if (enc_q.size() == 0) begin
                    check(0, "R2", "unexpected enc_valid_o", 1, 0);
                end else begin
                    enc_item_t e;
                    e = enc_q.pop_front();
                    check(e.due == cyc, "R2", "encoder latency", cyc, e.due);
                    check(enc_packet_o == e.pkt, "R1", "encoded packet", enc_packet_o, e.pkt);
                end
            end else begin
                if (enc_q.size() != 0 && enc_q[0].due == cyc)
                    check(0, "R2", "enc_valid_o missing", 0, 1);
                check(enc_packet_o == last_pkt, "R10", "encoder hold", enc_packet_o, last_pkt);
            end
            if (dec_valid_o) begin
                if (dec_q.size() == 0) begin
                    check(0, "R8", "unexpected dec_valid_o", 1, 0);
                end else begin
                    dec_item_t d;
                    d = dec_q.pop_front();
                    check(d.due == cyc, "R8", "decoder latency", cyc, d.due);
                    check(dec_data_o == d.data, d.req, "decoded data", dec_data_o, d.data);
                    check(dec_syndrome_o == d.syn, "R6", "syndrome", dec_syndrome_o, d.syn);
                    check(dec_corrected_o == d.corr, d.req, "corrected flag", dec_corrected_o, d.corr);
                    check(dec_uncorrectable_o == d.unc, d.req, "uncorrectable flag",
                          dec_uncorrectable_o, d.unc);
                end
            end else begin
                if (dec_q.size() != 0 && dec_q[0].due == cyc)
                    check(0, "R8", "dec_valid_o missing", 0, 1);
                check(dec_data_o == last_data && dec_syndrome_o == last_syn &&
                      dec_corrected_o == last_corr, "R10", "decoder hold",
                      {dec_data_o, dec_syndrome_o}, {last_data, last_syn});
            end
        end
        last_pkt  = enc_packet_o;
        last_data = dec_data_o;
        last_syn  = dec_syndrome_o;
        last_corr = dec_corrected_o;
    end

    task automatic check_reset_state(input string note);
        check(!enc_valid_o && enc_packet_o == '0, "R9", {note, " encoder cleared"},
              {enc_valid_o, enc_packet_o}, 0);
        check(!dec_valid_o && dec_data_o == '0 && dec_syndrome_o == '0 &&
              !dec_corrected_o && !dec_uncorrectable_o, "R9", {note, " decoder cleared"},
              {dec_valid_o, dec_data_o, dec_syndrome_o, dec_corrected_o, dec_uncorrectable_o}, 0);
    endtask

    // Watchdog: an expired run counts as a failure and still reports.
    initial begin
        repeat (WATCHDOG) @(posedge clk);
        check(0, "R2", "watchdog expired", cyc, WATCHDOG);
        finish_run();
    end

    // Main stimulus.
    initial begin
        logic [10:0] pkt;
        logic [6:0]  ew;
        int n;
        // Reset state with a valid input present (R9).
        enc_valid_i  = 1'b1;
        enc_data_i   = 7'h55;
        dec_valid_i  = 1'b1;
        dec_packet_i = 11'h7ff;
        repeat (2) @(negedge clk);
        check_reset_state("power-up");
        rst_n       = 1'b1;
        enc_valid_i = 1'b0;
        dec_valid_i = 1'b0;
        n = 0;
        // Every word, clean (R3) and with each single flip (R4 data, R5 parity),
        // while the encoder runs concurrently on a shifted sequence (R11).
        for (int w = 0; w < 128; w++) begin
            for (int f = -1; f < 11; f++) begin
                pkt = {w[6:0], ref_par(w[6:0])};
                if (f >= 0) pkt[f] = ~pkt[f];
                ew = 7'((w * 37 + f + 5) % 128);
                if (f < 0)
                    step(1, ew, 1, pkt, w[6:0], 0, 0, "R3");
                else if (f >= 4)
                    step(1, ew, 1, pkt, w[6:0], 1, 0, "R4");
                else
                    step(1, ew, 1, pkt, w[6:0], 1, 0, "R5");
                n++;
            end
            // Idle on both sides: outputs must hold (R10).
            step(0, 7'h00, 0, 11'h000, 7'h00, 0, 0, "R10");
        end
        // Unmatched syndromes: 1100 (W,X), 0110 (X,Y), 1101 (F,W), 0111 (G,X) -> R7.
        for (int w = 0; w < 128; w += 9) begin
            pkt = {w[6:0], ref_par(w[6:0])} ^ 11'b000_0000_1100;
            step(1, w[6:0], 1, pkt, pkt[10:4], 0, 1, "R7");
            pkt = {w[6:0], ref_par(w[6:0])} ^ 11'b000_0000_0110;
            step(0, 7'h00, 1, pkt, pkt[10:4], 0, 1, "R7");
            pkt = {w[6:0], ref_par(w[6:0])} ^ 11'b000_0010_1000;
            step(1, ~w[6:0], 1, pkt, pkt[10:4], 0, 1, "R7");
            pkt = {w[6:0], ref_par(w[6:0])} ^ 11'b000_0001_0100;
            step(1, w[6:0], 1, pkt, pkt[10:4], 0, 1, "R7");
        end
        step(0, 7'h00, 0, 11'h000, 7'h00, 0, 0, "R10");
        step(0, 7'h00, 0, 11'h000, 7'h00, 0, 0, "R10");
        // Mid-run reset with valid inputs present (R9).
        @(negedge clk);
        rst_n        = 1'b0;
        enc_valid_i  = 1'b1;
        enc_data_i   = 7'h2a;
        dec_valid_i  = 1'b1;
        dec_packet_i = 11'h5a5;
        @(negedge clk);
        check_reset_state("mid-run");
        rst_n       = 1'b1;
        enc_valid_i = 1'b0;
        dec_valid_i = 1'b0;
        repeat (3) @(negedge clk);
        check(enc_q.size() == 0 && dec_q.size() == 0, "R2", "queues drained",
              enc_q.size() + dec_q.size(), 0);
        check(n == 1536, "R11", "concurrent items driven", n, 1536);
        finish_run();
    end
endmodule